// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-pin general-purpose I/O port on a simple memory-mapped register bus. Each pin is either an output or an input, as set by a direction register. When a pin is an output, the port drives it from an output latch and raises its output enable. When a pin is an input, the port samples it through a two-flop synchronizer.

The data window is addressed in an unusual way. The word address of an access is itself a per-pin bit mask. A write changes only the selected pins, so software can set or clear any group of pins in one store, with no read-modify-write and no locking against other code using the same port. A read returns the selected pins and zeros in every other bit position.

A bus access takes one cycle and uses byte-wide data. Read data is registered, so it appears one clock after the read access and holds until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is active and after it is released, pin_oe is 0x00, pin_out is 0x00 and bus_rdata is 0x00.
- R2: A write to byte offset 0x400 loads the direction register from bus_wdata. A 1 in bit n makes pin n an output. pin_oe equals the direction register from the next clock on. A read of 0x400 returns the direction register.
- R3: A write to the data window (offsets 0x000 to 0x3FC, address bits [11:10] zero) uses address bits [9:2] as a mask. In that mask, address bit n+2 selects pin n. The write updates the latch bit of a selected output pin from bus_wdata bit n. Every other latch bit keeps its value. pin_out shows the latch from the next clock on.
- R4: A data write to a pin that is an input leaves its latch bit unchanged. The value written does not appear on pin_out when that pin is later made an output.
- R5: A data-window read returns, in bit n, the pin value of pin n when address bit n+2 is 1, and 0 when that address bit is 0.
- R6: For an input pin, the value read is pin_in delayed by two synchronizer stages. A change of pin_in presented before clock edge k is first returned by a read accepted at edge k+2.
- R7: For an output pin, a data read returns the latch bit, whatever pin_in carries on that pin.
- R8: Any offset that is neither the data window nor 0x400 reads as 0x00. A write there changes no state. This covers 0x404 to 0x41C and anything above.
- R9: bus_rdata is updated only by a read access, with bus_sel=1 and bus_wr=0. It is valid in the cycle after that access and holds through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output latch driven to the pins |
| pin_oe | output | 8 | Per-pin output enable (1 = drive) |

## Verification
Several rules hold on every cycle, and the assertions check them continuously:
- a direction write lands on pin_oe one clock later;
- a data write never disturbs a latch bit outside the mask of selected output pins;
- masked-off read bits are zero;
- accesses to unused offsets read zero and change nothing;
- bus_rdata holds when no read is accepted.

Other behaviour needs the bench's scenarios. This covers the exact two-clock synchronizer latency on input reads. It also covers values written to input pins staying lost after a direction change, and output pins reading back the latch against a conflicting pin_in. The reference model compares all outputs on every clock.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  // Classification of one bus access after address decode.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2,
    ACC_VOID = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/gpm_decode.sv
module gpm_decode
  import gpm_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_kind_e         kind,
  output logic              wr_en,
  output logic              rd_en,
  output logic [NPINS-1:0]  mask
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int DIR_WORD = 1 << NPINS;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_byte_lane;

  assign word             = bus_addr[ADDR_W-1:2];
  assign unused_byte_lane = bus_addr[1:0];
  assign mask             = word[NPINS-1:0];
  assign wr_en            = bus_sel & bus_wr;
  assign rd_en            = bus_sel & ~bus_wr;

  always_comb begin
    kind = ACC_NONE;
    if (bus_sel) begin
      if (word[WORD_W-1:NPINS] == '0) begin
        kind = ACC_DATA;
      end else if (word == WORD_W'(DIR_WORD)) begin
        kind = ACC_DIR;
      end else begin
        kind = ACC_VOID;
      end
    end
  end
endmodule

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] dout
);
  logic [STAGES-1:0][NPINS-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [NPINS-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_chain
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
  import gpm_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  acc_kind_e        kind,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] lat_q
);
  logic             dir_en;
  logic             lat_en;
  logic [NPINS-1:0] dir_d;
  logic [NPINS-1:0] lat_d;
  logic [NPINS-1:0] lat_sel;

  always_comb begin
    dir_en  = wr_en && (kind == ACC_DIR);
    lat_en  = wr_en && (kind == ACC_DATA);
    // Only output pins picked by the address mask take the new value.
    lat_sel = mask & dir_q;
    dir_d   = wdata;
    lat_d   = (lat_q & ~lat_sel) | (wdata & lat_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (lat_en) lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/gpm_readback.sv
module gpm_readback
  import gpm_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  acc_kind_e        kind,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] lat_q,
  input  logic [NPINS-1:0] sync_q,
  output logic [NPINS-1:0] rdata
);
  logic [NPINS-1:0] pin_view;
  logic [NPINS-1:0] rdata_d;

  genvar b;
  generate
    for (b = 0; b < NPINS; b++) begin : g_view
      assign pin_view[b] = dir_q[b] ? lat_q[b] : sync_q[b];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      ACC_DATA: rdata_d = pin_view & mask;
      ACC_DIR:  rdata_d = dir_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpm_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  logic             rst_meta_q;
  logic             rst_n_sync;
  acc_kind_e        kind;
  logic             wr_en;
  logic             rd_en;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] sync_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  gpm_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .kind     (kind),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .mask     (mask)
  );

  gpm_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (pin_in),
    .dout  (sync_q)
  );

  gpm_regs #(.NPINS(NPINS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .wr_en (wr_en),
    .kind  (kind),
    .mask  (mask),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .lat_q (lat_q)
  );

  gpm_readback #(.NPINS(NPINS)) u_readback (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .rd_en  (rd_en),
    .kind   (kind),
    .mask   (mask),
    .dir_q  (dir_q),
    .lat_q  (lat_q),
    .sync_q (sync_q),
    .rdata  (bus_rdata)
  );

  assign pin_out = lat_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpm_chk.sv
module gpm_chk #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);
  localparam int DIR_WORD = 1 << NPINS;

  logic [ADDR_W-3:0] c_word;
  logic [NPINS-1:0]  c_mask;
  logic              c_data;
  logic              c_dir;
  logic              c_void;

  assign c_word = bus_addr[ADDR_W-1:2];
  assign c_mask = bus_addr[NPINS+1:2];
  assign c_data = (32'(c_word) < DIR_WORD);
  assign c_dir  = (32'(c_word) == DIR_WORD);
  assign c_void = !c_data && !c_dir;

  // R2: direction write lands on the output enables one clock later
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && bus_wr && c_dir) |=> (pin_oe == $past(bus_wdata)));

  // R3: data write touches only masked output pins
  p_mask_only_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && bus_wr && c_data) |=>
      (((pin_out ^ $past(pin_out)) & ~($past(c_mask) & $past(pin_oe))) == '0));

  // R3: with no write, neither latch nor direction moves
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(bus_sel && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R5: masked-off bits of a data read are zero
  p_read_masked_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && !bus_wr && c_data) |=> ((bus_rdata & ~$past(c_mask)) == '0));

  // R8: unused offsets read zero
  p_void_read_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && !bus_wr && c_void) |=> (bus_rdata == '0));

  // R8: unused offsets accept no write
  p_void_write_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && bus_wr && c_void) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R9: read data holds unless a read is accepted
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  // R1: outputs are quiet while the block is held in reset
  always_comb begin
    if (!rst_n_sync) begin
      p_reset_quiet_r1: assert (pin_oe == '0 || $isunknown(pin_oe));
    end
  end
endmodule

bind gpio_mask_port gpm_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  gpio_mask_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  logic [7:0] m_dir, m_lat, m_rd;
  logic [7:0] in_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 8'h00;
      m_lat = 8'h00;
      m_rd  = 8'h00;
      in_hist = '{8'h00, 8'h00};
    end else begin
      int word;
      logic [7:0] msk;
      logic [7:0] seen;
      word = int'(bus_addr) / 4;
      msk  = bus_addr[9:2];
      seen = in_hist[1];
      if (bus_sel && !bus_wr) begin
        if (word < 256)       m_rd = ((m_dir & m_lat) | (~m_dir & seen)) & msk;
        else if (word == 256) m_rd = m_dir;
        else                  m_rd = 8'h00;
      end
      if (bus_sel && bus_wr) begin
        if (word < 256)       m_lat = (m_lat & ~(msk & m_dir)) | (bus_wdata & msk & m_dir);
        else if (word == 256) m_dir = bus_wdata;
      end
      in_hist.push_front(pin_in);
      void'(in_hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cycles > 3) begin
      chk("R2 pin_oe vs model", pin_oe, m_dir);
      chk("R3 pin_out vs model", pin_out, m_lat);
      chk("R5 bus_rdata vs model", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] r);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    r = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    logic [7:0] r, r0, r1, r2;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pin_oe in reset", pin_oe, 8'h00);
    chk("R1 pin_out in reset", pin_out, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pin_oe after reset", pin_oe, 8'h00);
    chk("R1 bus_rdata after reset", bus_rdata, 8'h00);

    // R2: direction register
    bus_write(12'h400, 8'hF0);
    chk("R2 pin_oe after dir write", pin_oe, 8'hF0);
    bus_read(12'h400, r);
    chk("R2 dir readback", r, 8'hF0);

    // R3/R4: full-mask write, only output pins take it
    bus_write(12'h3FC, 8'hFF);
    chk("R4 input pins ignore data write", pin_out, 8'hF0);
    // R3: partial mask 0x30
    bus_write(12'h0C0, 8'h00);
    chk("R3 masked clear of pins 5:4", pin_out, 8'hC0);
    // R4: lost value stays lost after direction change
    bus_write(12'h400, 8'hFF);
    chk("R4 old write absent after dir change", pin_out, 8'hC0);
    bus_write(12'h03C, 8'h0F);
    chk("R3 rewrite after dir change", pin_out, 8'hCF);

    // R6/R7: mixed directions
    bus_write(12'h400, 8'h0F);
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    bus_read(12'h3FC, r);
    chk("R7 outputs read latch, inputs read pins", r, 8'hAF);
    bus_read(12'h204, r);
    chk("R5 mask 0x81 read", r, 8'h81);
    chk("R7 pin_out unaffected by pin_in", pin_out, 8'hCF);

    // R6: two-stage latency
    pin_in = 8'h50;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3C0;
    @(negedge clk); r0 = bus_rdata;
    @(negedge clk); r1 = bus_rdata;
    @(negedge clk); r2 = bus_rdata;
    bus_sel = 1'b0;
    chk("R6 read at edge k", r0, 8'hA0);
    chk("R6 read at edge k+1", r1, 8'hA0);
    chk("R6 read at edge k+2", r2, 8'h50);

    // R8: unused offsets
    bus_write(12'h404, 8'hFF);
    bus_read(12'h404, r);
    chk("R8 unused offset reads zero", r, 8'h00);
    bus_read(12'h400, r);
    chk("R8 dir unchanged by unused write", r, 8'h0F);
    bus_write(12'h800, 8'h00);
    chk("R8 high offset write ignored", pin_out, 8'hCF);
    bus_read(12'h800, r);
    chk("R8 high offset reads zero", r, 8'h00);
    bus_read(12'h41C, r);
    chk("R8 offset 0x41C reads zero", r, 8'h00);

    // R9: read data holds across writes and idle
    bus_read(12'h400, r);
    bus_write(12'h3FC, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", bus_rdata, 8'h0F);
    chk("R3 low latch cleared", pin_out, 8'hC0);
    bus_read(12'h3FC, r);
    chk("R5 final full read", r, 8'h50);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule